// File: doc/BRIEF.md
# Eight-Channel Mailbox Doorbell Unit

This block is the hardware half of a message mailbox between a host processor and a power-management controller. It has eight channels. Each channel owns two header bytes in a shared 16-byte window. One is a request byte that the host writes, and the other is an acknowledge byte that the controller writes. Each channel also has one busy bit and one acknowledge-pending bit.

A host transaction runs in a fixed order. The host polls the busy register until the channel's bit is clear. It then writes the request header and rings the channel's doorbell by writing a 1 to that bit of the doorbell register. The controller pulses a per-channel consume strobe once it has taken the request, and this clears busy. When the controller has an answer, it writes the acknowledge header and pulses a per-channel acknowledge strobe. That strobe sets the pending bit and raises the interrupt. The host reads the pending register, handles each set bit, and clears the bits it handled by writing 1s back.

Each side has its own byte-wide bus port. The reset input is expected to be synchronised to the clock before it reaches the block.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, every header byte, every busy bit and every pending bit reads 0, and irq is low. A header byte of 0 means "no header".
- R2: Host addresses 0..7 hold the request header of channels 0..7. A host write there stores the byte. Both the host (same address) and the far side (far address n) read it back.
- R3: Host addresses 8..15 and far addresses 8..15 hold the acknowledge header of channels 0..7. A far write there stores the byte, and the host reads it at the same address.
- R4: A host write to addresses 8..15 leaves the acknowledge headers unchanged. A far write to addresses 0..7 leaves the request headers unchanged.
- R5: A host write to address 16 (doorbell) sets busy bit n for every 1 in bit n of the data. Bits written as 0 have no effect.
- R6: Address 17 reads the busy bits in bits 7..0 and is read-only, so a host write there changes nothing. A pulse on f_consume[n] clears busy bit n.
- R7: A pulse on f_ack[n] sets pending bit n, and address 18 reads the pending bits. Writing 1 to bit n at address 18 clears that bit. Writing 0 has no effect.
- R8: If a set and a clear of the same busy or pending bit fall in the same cycle, the bit ends up set.
- R9: irq is high in exactly the cycles in which at least one pending bit is set. It follows the pending register with no extra delay.
- R10: Reads are registered. h_rdata and f_rdata show the addressed value one clock after the request and hold it until the next read. Address 16 and addresses 19..31 read 0.
- R11: A host write of 8'hFF to address 18 clears every pending bit at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access request |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 5 | Host address: 0..15 header window, 16..31 registers |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| f_req | input | 1 | Far-side access request |
| f_wr | input | 1 | Far-side access is a write |
| f_addr | input | 4 | Far-side header window address |
| f_wdata | input | 8 | Far-side write data |
| f_rdata | output | 8 | Far-side read data, registered |
| f_consume | input | 8 | Per-channel request-consumed strobes, clear busy |
| f_ack | input | 8 | Per-channel acknowledge strobes, set pending |
| irq | output | 1 | Acknowledge interrupt, high while any pending bit is set |

## Verification
The bench drives a doorbell and a consume of the same channel in the same cycle, and does the same with an acknowledge and a W1C. A design where the clear wins would drop a fresh request or lose an acknowledge without raising an interrupt. It also writes into the half of the header window that belongs to the other side, and writes to the read-only busy address. A design that decodes these loosely would corrupt headers or busy state. Random traffic on both ports, mixed with strobes, checks every read against a model. That model catches a read path that returns post-edge values and an interrupt that lags the pending register.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // register offsets inside the upper half of the host address space
  localparam int unsigned REG_DOORBELL = 0;
  localparam int unsigned REG_BUSY     = 1;
  localparam int unsigned REG_PENDING  = 2;
endpackage

// File: rtl/mbox_flag_bank.sv
module mbox_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_nxt;
  logic         upd;

  // set has priority over clear for the same bit
  always_comb begin
    q_nxt = (q_r & ~clr_i) | set_i;
    upd   = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R8: a requested set is visible after the edge, whatever clear came with it
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_r & $past(set_i)) == $past(set_i)));
  // R6/R7: a clear without a matching set leaves the bit low
  p_clear_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((q_r & $past(clr_i & ~set_i)) == '0));
  // R6/R7: no set and no clear means no change
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(q_r));
endmodule

// File: rtl/mbox_hdr_mem.sv
module mbox_hdr_mem #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned AW = $clog2(2 * N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_idx_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rbyte_o,
  input  logic          f_we_i,
  input  logic [AW-1:0] f_idx_i,
  input  logic [DW-1:0] f_wdata_i,
  output logic [DW-1:0] f_rbyte_o
);
  localparam int unsigned  DEPTH = 2 * N;
  localparam logic [AW-1:0] NLIM = AW'(N);

  logic [DW-1:0] hdr_q   [DEPTH];
  logic [DW-1:0] hdr_nxt [DEPTH];
  logic          h_ok, f_ok;
  logic [N*DW-1:0] req_flat, ack_flat;

  // host owns the request half, far side owns the acknowledge half
  always_comb begin
    h_ok = h_we_i && (h_idx_i < NLIM);
    f_ok = f_we_i && (f_idx_i >= NLIM);
    for (int i = 0; i < DEPTH; i++) hdr_nxt[i] = hdr_q[i];
    if (h_ok) hdr_nxt[h_idx_i] = h_wdata_i;
    if (f_ok) hdr_nxt[f_idx_i] = f_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hdr_q[i] <= '0;
    end else if (h_ok || f_ok) begin
      for (int i = 0; i < DEPTH; i++) hdr_q[i] <= hdr_nxt[i];
    end
  end

  assign h_rbyte_o = hdr_q[h_idx_i];
  assign f_rbyte_o = hdr_q[f_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign req_flat[g*DW +: DW] = hdr_q[g];
    assign ack_flat[g*DW +: DW] = hdr_q[g+N];
  end

  // R4: only host writes below N touch the request half
  p_req_half_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_we_i && (h_idx_i < NLIM)) |=> $stable(req_flat));
  // R4: only far writes at N and above touch the acknowledge half
  p_ack_half_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_we_i && (f_idx_i >= NLIM)) |=> $stable(ack_flat));
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned AW  = $clog2(2 * N),
  localparam int unsigned HAW = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_req,
  input  logic           h_wr,
  input  logic [HAW-1:0] h_addr,
  input  logic [DW-1:0]  h_wdata,
  output logic [DW-1:0]  h_rdata,
  input  logic           f_req,
  input  logic           f_wr,
  input  logic [AW-1:0]  f_addr,
  input  logic [DW-1:0]  f_wdata,
  output logic [DW-1:0]  f_rdata,
  input  logic [N-1:0]   f_consume,
  input  logic [N-1:0]   f_ack,
  output logic           irq
);
  import mbox_pkg::*;

  logic          h_we, h_re, f_we, f_re, in_regs;
  logic [AW-1:0] off;
  logic [N-1:0]  db_set, pend_clr, busy, pend;
  logic [DW-1:0] h_hbyte, f_hbyte, h_rd_nxt, h_rd_q, f_rd_q;

  always_comb begin
    h_we     = h_req && h_wr;
    h_re     = h_req && !h_wr;
    f_we     = f_req && f_wr;
    f_re     = f_req && !f_wr;
    in_regs  = h_addr[HAW-1];
    off      = h_addr[AW-1:0];
    db_set   = (h_we && in_regs && (off == AW'(REG_DOORBELL))) ? h_wdata[N-1:0] : '0;
    pend_clr = (h_we && in_regs && (off == AW'(REG_PENDING)))  ? h_wdata[N-1:0] : '0;
  end

  mbox_hdr_mem #(.N(N), .DW(DW)) u_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_we_i    (h_we && !in_regs),
    .h_idx_i   (off),
    .h_wdata_i (h_wdata),
    .h_rbyte_o (h_hbyte),
    .f_we_i    (f_we),
    .f_idx_i   (f_addr),
    .f_wdata_i (f_wdata),
    .f_rbyte_o (f_hbyte)
  );

  mbox_flag_bank #(.W(N)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (db_set),
    .clr_i (f_consume),
    .q_o   (busy)
  );

  mbox_flag_bank #(.W(N)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (f_ack),
    .clr_i (pend_clr),
    .q_o   (pend)
  );

  always_comb begin
    h_rd_nxt = '0;
    if (!in_regs) begin
      h_rd_nxt = h_hbyte;
    end else if (off == AW'(REG_BUSY)) begin
      h_rd_nxt[N-1:0] = busy;
    end else if (off == AW'(REG_PENDING)) begin
      h_rd_nxt[N-1:0] = pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rd_q <= '0;
      f_rd_q <= '0;
    end else begin
      if (h_re) h_rd_q <= h_rd_nxt;
      if (f_re) f_rd_q <= f_hbyte;
    end
  end

  assign h_rdata = h_rd_q;
  assign f_rdata = f_rd_q;
  assign irq     = |pend;

  // R9: the interrupt can only rise after an acknowledge strobe
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(f_ack) != '0));
  // R10: read data holds while neither side issues a read
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_re && !f_re) |=> ($stable(h_rdata) && $stable(f_rdata)));
  // R11: a full clear with no acknowledge strobe drops the interrupt
  p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && in_regs && (off == AW'(REG_PENDING)) && (h_wdata[N-1:0] == '1) && (f_ack == '0)) |=> !irq);
endmodule

// File: tb/mbox_doorbell_bench.sv
`timescale 1ns/1ps
module mbox_doorbell_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       h_req, h_wr, f_req, f_wr;
  logic [4:0] h_addr;
  logic [3:0] f_addr;
  logic [7:0] h_wdata, f_wdata, h_rdata, f_rdata, f_consume, f_ack;
  logic       irq;

  int total = 0;
  int bad   = 0;

  logic [7:0] m_hdr [16];
  logic [7:0] m_busy, m_pend;

  always #5 clk = ~clk;

  mbox_doorbell u_mbox_doorbell (
    .clk(clk), .rst_n(rst_n),
    .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .f_req(f_req), .f_wr(f_wr), .f_addr(f_addr), .f_wdata(f_wdata), .f_rdata(f_rdata),
    .f_consume(f_consume), .f_ack(f_ack), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] host_view(input logic [4:0] a);
    if (a < 5'd16)       return m_hdr[a[3:0]];
    else if (a == 5'd17) return m_busy;
    else if (a == 5'd18) return m_pend;
    else                 return 8'h00;
  endfunction

  function automatic string host_tag(input logic [4:0] a);
    if (a < 5'd8)        return "R2";
    else if (a < 5'd16)  return "R3";
    else if (a == 5'd17) return "R5";
    else if (a == 5'd18) return "R7";
    else                 return "R10";
  endfunction

  task automatic idle();
    h_req = 0; h_wr = 0; h_addr = '0; h_wdata = '0;
    f_req = 0; f_wr = 0; f_addr = '0; f_wdata = '0;
    f_consume = '0; f_ack = '0;
  endtask

  // inputs are already driven at a falling edge; run one clock and check
  task automatic step(input string irq_tag);
    logic [7:0] exp_h, exp_f, bset, pclr;
    logic       hr, fr;
    string      tag;
    hr    = h_req && !h_wr;
    fr    = f_req && !f_wr;
    exp_h = host_view(h_addr);
    exp_f = m_hdr[f_addr];
    tag   = host_tag(h_addr);
    bset  = (h_req && h_wr && h_addr == 5'd16) ? h_wdata : 8'h00;
    pclr  = (h_req && h_wr && h_addr == 5'd18) ? h_wdata : 8'h00;
    @(posedge clk);
    if (h_req && h_wr && h_addr < 5'd8) m_hdr[h_addr[3:0]] = h_wdata;
    if (f_req && f_wr && f_addr >= 4'd8) m_hdr[f_addr] = f_wdata;
    m_busy = (m_busy & ~f_consume) | bset;
    m_pend = (m_pend & ~pclr) | f_ack;
    @(negedge clk);
    if (hr) chk(tag, h_rdata, exp_h);
    if (fr) chk("R2/R3 far read", f_rdata, exp_f);
    chk(irq_tag, {7'd0, irq}, {7'd0, |m_pend});
    idle();
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [7:0] d);
    h_req = 1; h_wr = 1; h_addr = a; h_wdata = d; step("R9");
  endtask
  task automatic hread(input logic [4:0] a);
    h_req = 1; h_wr = 0; h_addr = a; step("R9");
  endtask
  task automatic fwrite(input logic [3:0] a, input logic [7:0] d);
    f_req = 1; f_wr = 1; f_addr = a; f_wdata = d; step("R9");
  endtask
  task automatic fread(input logic [3:0] a);
    f_req = 1; f_wr = 0; f_addr = a; step("R9");
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'h5eed_0042);
    for (int i = 0; i < 16; i++) m_hdr[i] = 8'h00;
    m_busy = 8'h00; m_pend = 8'h00;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: everything reads zero after reset
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 32; a++) begin
      h_req = 1; h_wr = 0; h_addr = 5'(a); step("R1");
    end

    // R2 request header write and read back from both sides
    hwrite(5'd3, 8'hA5); hread(5'd3); fread(4'd3);
    // R3 acknowledge header from far side
    fwrite(4'd11, 8'h5C); hread(5'd11);
    // R4 wrong-side writes ignored
    hwrite(5'd11, 8'hEE); hread(5'd11);
    fwrite(4'd3, 8'h77); hread(5'd3); fread(4'd3);
    // R5 doorbell: only 1 bits set
    hwrite(5'd16, 8'h09); hread(5'd17);
    hwrite(5'd16, 8'h00); hread(5'd17);
    // R6 busy is read-only; consume clears
    hwrite(5'd17, 8'hFF); hread(5'd17);
    f_consume = 8'h01; step("R6"); hread(5'd17);
    // R8 doorbell and consume on the same bit
    h_req = 1; h_wr = 1; h_addr = 5'd16; h_wdata = 8'h08; f_consume = 8'h08; step("R8");
    hread(5'd17);
    // R7 acknowledge sets pending, W1C clears, 0 bits ignored
    f_ack = 8'h24; step("R9 irq rise"); hread(5'd18);
    hwrite(5'd18, 8'h04); hread(5'd18);
    hwrite(5'd18, 8'h00); hread(5'd18);
    // R8 acknowledge and W1C on the same bit
    h_req = 1; h_wr = 1; h_addr = 5'd18; h_wdata = 8'h20; f_ack = 8'h20; step("R8");
    hread(5'd18);
    // R11 clear all
    f_ack = 8'hC3; step("R9"); hwrite(5'd18, 8'hFF); hread(5'd18);
    // R10 doorbell and unmapped addresses read zero, read data holds
    hread(5'd16); hread(5'd25); hread(5'd31);
    hread(5'd3); step("R10"); chk("R10 hold", h_rdata, m_hdr[3]);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom;
      h_req = r[0]; h_wr = r[1];
      h_addr = (r[4:2] == 3'd0) ? (5'd16 + 5'(r[6:5])) : 5'($urandom_range(0, 31));
      h_wdata = 8'($urandom);
      f_req = r[7]; f_wr = r[8]; f_addr = 4'($urandom); f_wdata = 8'($urandom);
      f_consume = (r[11:9] == 3'd0) ? 8'($urandom) : 8'h00;
      f_ack     = (r[14:12] == 3'd0) ? 8'($urandom) : 8'h00;
      step("R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule